// File: doc/BRIEF.md
# Dual-Channel Converter Command Front End

This block is the digital control section of a two-channel 10-bit voltage-output converter. A host drives three wires: an active-low frame select, a serial clock and a serial data line. While the frame select is low, each rising serial clock shifts one data bit into a 16-bit register. When the frame select returns high, the block decodes the top four bits of that word as a command and carries it out.

Each channel has two 10-bit registers. The staging register receives new codes. The live register drives the converter. Commands can stage a code for one channel, stage the same code for both, copy both staged values to both live registers at once, or combine a staging write with that copy. The block also holds a power state. A sleep command raises a flag that the analog side uses to put its outputs into high impedance. Every copy command also clears that flag. A staging-only write leaves the flag as it is, so new codes can be prepared while the part is asleep.

The three serial inputs are asynchronous to the system clock. They are brought across on a synchroniser, and their edges are found in the system clock domain. A frame with fewer than 16 serial clocks is dropped. A frame with more than 16 keeps only the last 16 bits.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset is applied, both live outputs read 0 and the sleep flag is 0 (awake). This holds for reset at start-up and for reset applied later during operation.
- R2: A bit is taken from `ser_dat` only on a rising `ser_clk` while `frame_n` is low, and bits arrive MSB first. A rising serial clock that coincides with the rise of `frame_n` is not shifted in.
- R3: The command runs once, on the rise of `frame_n`. It runs only if at least 16 serial clocks came in during the frame, and then it uses the last 16 bits. The word layout is: bits 15..12 command, bits 11..2 data code, bits 1..0 ignored.
- R4: Command 0001 stages the data code for channel A, and command 0010 stages it for channel B. Neither changes a live output or the sleep flag.
- R5: Command 1000 copies both staged codes into both live registers in the same cycle and clears the sleep flag.
- R6: Command 1001 stages the code for A, and command 1010 stages it for B. In the same step, both live registers take the staged values, including the new one, and the sleep flag clears.
- R7: Command 1101 clears the sleep flag and changes no register. Command 1110 sets the sleep flag, ignores the data code and changes no register.
- R8: Command 1111 stages the same code for both channels, copies it to both live registers and clears the sleep flag.
- R9: Commands 0000, 0011 to 0111, 1011 and 1100 change no register and leave the sleep flag as it is.
- R10: Staging writes made while asleep keep the sleep flag set, and the live outputs keep their values through sleep. A later copy command then shows the staged values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; a rising edge shifts one bit |
| frame_n | input | 1 | Frame select, active low; its rise executes the command |
| ser_dat | input | 1 | Serial data, MSB first |
| dac_a | output | 10 | Live code for channel A |
| dac_b | output | 10 | Live code for channel B |
| dac_sleep | output | 1 | 1 = analog outputs in high impedance |

## Verification
Two events can be seen in the same system cycle: the end of a frame, which executes the command, and a rising serial clock, which would shift a bit. The bench raises `ser_clk` and `frame_n` in the same cycle, with `ser_dat` set so that an extra shift would turn the command into a different one. The test passes only if the live outputs match the 16-bit word that was sent. The bench also interleaves staging writes with sleep. It then checks that the sleep flag is unchanged and that the staged codes appear only after a later copy command.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int CMD_W = 4;
  localparam int NCH   = 2;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP        = 4'b0000,
    OP_STAGE_A    = 4'b0001,
    OP_STAGE_B    = 4'b0010,
    OP_COPY       = 4'b1000,
    OP_STAGE_A_CP = 4'b1001,
    OP_STAGE_B_CP = 4'b1010,
    OP_WAKE       = 4'b1101,
    OP_SLEEP      = 4'b1110,
    OP_STAGE_ALL  = 4'b1111
  } op_e;

  typedef struct packed {
    logic [NCH-1:0] stage;
    logic           copy;
    logic           wake;
    logic           sleep;
  } act_t;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcc_rx.sv
module dcc_rx #(
  parameter int WORD_W = 16,
  parameter int KEEP_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              frame_s,
  input  logic              dat_s,
  output logic [KEEP_W-1:0] word,
  output logic              exec
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q, frame_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic              sclk_rise, frame_rise, frame_fall, shift_en, cnt_en;

  always_comb begin
    sclk_rise  = sclk_s & ~sclk_q;
    frame_rise = frame_s & ~frame_q;
    frame_fall = ~frame_s & frame_q;
    shift_en   = sclk_rise & ~frame_s;
    sh_d       = {sh_q[WORD_W-2:0], dat_s};
    cnt_base   = frame_fall ? '0 : cnt_q;
    cnt_d      = cnt_base;
    if (shift_en && cnt_base != FULL) cnt_d = cnt_base + 1'b1;
    cnt_en     = frame_fall | shift_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      frame_q <= frame_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign word = sh_q[WORD_W-1 -: KEEP_W];
  assign exec = frame_rise & (cnt_q == FULL);
endmodule

// File: rtl/dcc_decode.sv
module dcc_decode
  import dcc_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output act_t             act
);
  always_comb begin
    act = '0;
    case (cmd)
      OP_STAGE_A:    act.stage[0] = 1'b1;
      OP_STAGE_B:    act.stage[1] = 1'b1;
      OP_COPY:       begin act.copy = 1'b1; act.wake = 1'b1; end
      OP_STAGE_A_CP: begin act.stage[0] = 1'b1; act.copy = 1'b1; act.wake = 1'b1; end
      OP_STAGE_B_CP: begin act.stage[1] = 1'b1; act.copy = 1'b1; act.wake = 1'b1; end
      OP_WAKE:       act.wake = 1'b1;
      OP_SLEEP:      act.sleep = 1'b1;
      OP_STAGE_ALL:  begin act.stage = '1; act.copy = 1'b1; act.wake = 1'b1; end
      default:       act = '0;
    endcase
  end
endmodule

// File: rtl/dcc_regs.sv
module dcc_regs
  import dcc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec,
  input  act_t                  act,
  input  logic [DATA_W-1:0]     data,
  output logic [NCH*DATA_W-1:0] live,
  output logic                  sleep_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DATA_W-1:0] stg_q, stg_d, live_q;
    logic              stg_en, live_en;

    always_comb begin
      stg_en  = exec & act.stage[ch];
      live_en = exec & act.copy;
      stg_d   = stg_en ? data : stg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg_q <= '0;
      else if (stg_en) stg_q <= stg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       live_q <= '0;
      else if (live_en) live_q <= stg_d;
    end

    assign live[ch*DATA_W +: DATA_W] = live_q;
  end

  logic slp_q, slp_d, slp_en;

  always_comb begin
    slp_en = exec & (act.sleep | act.wake);
    slp_d  = act.sleep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slp_q <= 1'b0;
    else if (slp_en) slp_q <= slp_d;
  end

  assign sleep_o = slp_q;
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dcc_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int PAD_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              frame_n,
  input  logic              ser_dat,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              dac_sleep
);
  localparam int WORD_W = CMD_W + DATA_W + PAD_W;
  localparam int KEEP_W = CMD_W + DATA_W;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [2:0]        ser_s;
  logic [KEEP_W-1:0] word;
  logic              exec;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data;
  act_t              act;
  logic [NCH*DATA_W-1:0] live;

  dcc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n),
    .d({ser_clk, frame_n, ser_dat}), .q(ser_s)
  );

  dcc_rx #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n),
    .sclk_s(ser_s[2]), .frame_s(ser_s[1]), .dat_s(ser_s[0]),
    .word(word), .exec(exec)
  );

  assign cmd  = word[KEEP_W-1 -: CMD_W];
  assign data = word[DATA_W-1:0];

  dcc_decode u_dec (.cmd(cmd), .act(act));

  dcc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .exec(exec), .act(act), .data(data),
    .live(live), .sleep_o(dac_sleep)
  );

  assign dac_a = live[DATA_W-1:0];
  assign dac_b = live[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec,
  input logic [3:0]        cmd,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              dac_sleep
);
  logic is_res, is_wake;

  always_comb begin
    is_res  = (cmd inside {4'b0000, 4'b0011, 4'b0100, 4'b0101, 4'b0110,
                           4'b0111, 4'b1011, 4'b1100});
    is_wake = (cmd inside {4'b1000, 4'b1001, 4'b1010, 4'b1101, 4'b1111});
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(dac_a) && $stable(dac_b) && $stable(dac_sleep)); // R3

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (cmd == 4'b0001 || cmd == 4'b0010)
    |=> $stable(dac_a) && $stable(dac_b) && $stable(dac_sleep)); // R4

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_wake |=> !dac_sleep); // R5

  AST_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    exec && cmd == 4'b1110 |=> dac_sleep && $stable(dac_a) && $stable(dac_b)); // R7

  AST_BOTH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    exec && cmd == 4'b1111 |=> dac_a == dac_b); // R8

  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    exec && is_res |=> $stable(dac_a) && $stable(dac_b) && $stable(dac_sleep)); // R9
endmodule

bind dac_cmd_ctrl dcc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .cmd(cmd),
  .dac_a(dac_a), .dac_b(dac_b), .dac_sleep(dac_sleep)
);

// File: tb/sim_dac_cmd_ctrl.sv
module sim_dac_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WD_CYCLES  = 100000;
  localparam int NVEC       = 18;

  // entry: {cmd[4], data[10], exp_a[10], exp_b[10], exp_sleep[1]}
  localparam logic [34:0] VEC [NVEC] = '{
    {4'b0001, 10'd100,  10'd0,    10'd0,    1'b0},  // R4 stage A
    {4'b0010, 10'd200,  10'd0,    10'd0,    1'b0},  // R4 stage B
    {4'b1000, 10'd9,    10'd100,  10'd200,  1'b0},  // R5 copy both
    {4'b1110, 10'd555,  10'd100,  10'd200,  1'b1},  // R7 sleep
    {4'b0001, 10'd300,  10'd100,  10'd200,  1'b1},  // R10 stage while asleep
    {4'b0011, 10'd777,  10'd100,  10'd200,  1'b1},  // R9 reserved
    {4'b1000, 10'd0,    10'd300,  10'd200,  1'b0},  // R10 copy reveals staged
    {4'b1110, 10'd1,    10'd300,  10'd200,  1'b1},  // R7 sleep
    {4'b1101, 10'd2,    10'd300,  10'd200,  1'b0},  // R7 wake
    {4'b1010, 10'd1023, 10'd300,  10'd1023, 1'b0},  // R6 stage B + copy
    {4'b1001, 10'd0,    10'd0,    10'd1023, 1'b0},  // R6 stage A + copy
    {4'b1111, 10'd512,  10'd512,  10'd512,  1'b0},  // R8 both same
    {4'b1100, 10'd1,    10'd512,  10'd512,  1'b0},  // R9
    {4'b1011, 10'd2,    10'd512,  10'd512,  1'b0},  // R9
    {4'b0000, 10'd3,    10'd512,  10'd512,  1'b0},  // R9
    {4'b0111, 10'd4,    10'd512,  10'd512,  1'b0},  // R9
    {4'b1110, 10'd5,    10'd512,  10'd512,  1'b1},  // R7
    {4'b1111, 10'd7,    10'd7,    10'd7,    1'b0}   // R8 wakes from sleep
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       frame_n = 1'b1;
  logic       ser_dat = 1'b0;
  logic [9:0] dac_a, dac_b;
  logic       dac_sleep;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
    .ser_dat(ser_dat), .dac_a(dac_a), .dac_b(dac_b), .dac_sleep(dac_sleep)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [9:0] ea,
                       input logic [9:0] eb, input logic es);
    n_chk++;
    if (dac_a !== ea || dac_b !== eb || dac_sleep !== es) begin
      n_err++;
      $display("FAIL %s: got a=%0d b=%0d sleep=%0b, expected a=%0d b=%0d sleep=%0b",
               req, dac_a, dac_b, dac_sleep, ea, eb, es);
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input bit clash);
    frame_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      wait_clk(HALF);
      ser_clk = 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
    end
    wait_clk(HALF);
    if (clash) begin
      ser_dat = 1'b1;
      ser_clk = 1'b1;
      frame_n = 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
    end else begin
      frame_n = 1'b1;
    end
    wait_clk(10);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 power-on", 10'd0, 10'd0, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      frame({16'd0, VEC[v][34:31], VEC[v][30:21], 2'b10}, 16, 1'b0);
      check($sformatf("vector %0d", v), VEC[v][20:11], VEC[v][10:1], VEC[v][0]);
    end

    // R3: a 12-clock frame is dropped
    frame({20'd0, 12'hF0F}, 12, 1'b0);
    check("R3 short frame", 10'd7, 10'd7, 1'b0);

    // R3: a 20-clock frame keeps the last 16 bits (1111, code 33)
    frame({12'd0, 4'b1010, 4'b1111, 10'd33, 2'b00}, 20, 1'b0);
    check("R3 long frame", 10'd33, 10'd33, 1'b0);

    // R2: serial clock rising together with frame end is not shifted
    frame({16'd0, 4'b1001, 10'd44, 2'b01}, 16, 1'b1);
    check("R2 clock at frame end", 10'd44, 10'd33, 1'b0);

    // R1: reset during operation
    frame({16'd0, 4'b1110, 10'd0, 2'b00}, 16, 1'b0);
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 reset in operation", 10'd0, 10'd0, 1'b0);

    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout, expected run to end");
    finish_run();
  end
endmodule